// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits behind the host write port of a dual-plane NOR-style flash model. It turns the stream of bus write cycles into operation launches. The operations are word program, sector erase, chip erase and sector lock. It also keeps the interpreter mode: read, identification, bypass or erase-suspended. A separate timing unit carries out each launched operation and reports completion on `op_done`. The array, analog timing, high-voltage overrides and byte/word pin muxing are not part of the block.

Writes arrive as a valid-only stream: `wr_valid` qualifies `wr_addr`/`wr_data` for one clock. The block never applies back-pressure. A write that arrives while it may not be acted on is dropped and does not advance any sequence. Launches leave as one-cycle `start_valid` pulses with no ready, so the timing unit must take each pulse when it comes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `busy` and `erase_hold` are 0, and no `start_valid` is issued.
- R2: Program takes four writes: data AAh at address 555h, data 55h at address 2AAh, data A0h at address 555h, then the target address and data. One cycle after the fourth write, `start_valid` pulses with `start_op`=0 and carries that address and the full 16-bit data.
- R3: Sector erase takes six writes: the unlock pair, 80h at 555h, the unlock pair, then 30h at any address. It launches `start_op`=1 with that address. `start_plane` is 1 when address bits 18..16 are nonzero, otherwise 0.
- R4: With the same 80h prefix, a sixth write of 10h at 555h launches chip erase (`start_op`=2). A 60h third cycle followed by the unlock pair and 40h launches sector lock (`start_op`=3) at the sixth address.
- R5: With the 80h prefix, a sixth write of 20h at 555h enters bypass (`mode`=2). After that, every single write launches a program at its own address and data.
- R6: Bypass is left only by `rst_n` low. In bypass, codes B0h, 30h, F0h and AAh launch programs like any other data.
- R7: While a program or lock is running (from its launch until `op_done`), every write is dropped. No launch or mode change follows, and the sequence position is unchanged.
- R8: B0h written during an unsuspended erase keeps `busy` high for SUSP_DLY cycles. After that, `erase_hold` is 1, `busy` is 0 and `mode` reads 3. If `op_done` arrives in the same cycle as B0h, the erase completes and no suspend follows.
- R9: A single write of 30h resumes a suspended erase only if the plane of its address (bits 18..16 nonzero → 1) matches the erase's plane. Otherwise it is ignored.
- R10: While an erase is suspended, an erase sequence is refused (no launch). A program to a different sector (address bits 18..15) is launched. A program to the suspended sector is refused.
- R11: Only data bits 7..0 are compared against command codes.
- R12: A write that breaks a sequence ends it with no launch and sets `mode` to 0. This also applies from identification mode.
- R13: A 90h third cycle enters identification (`mode`=1). A single F0h write returns to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write cycle qualifier |
| wr_addr | input | 19 | Write word address |
| wr_data | input | 16 | Write data |
| op_done | input | 1 | Timing unit finished the current operation |
| start_valid | output | 1 | One-cycle operation launch |
| start_op | output | 2 | 0 program, 1 sector erase, 2 chip erase, 3 lock |
| start_addr | output | 19 | Target address of the launch |
| start_data | output | 16 | Data of the launch |
| start_plane | output | 1 | Plane of the launch (0 low plane, 1 high plane) |
| mode | output | 2 | 0 read, 1 identification, 2 bypass, 3 erase suspended |
| busy | output | 1 | Operation running or suspend pending |
| erase_hold | output | 1 | Erase is held in suspension |

## Verification
Two events can land in the same clock: the timing unit's completion of an erase and the host's suspend code. The bench drives `op_done` and a B0h write on the same edge. It then checks that `busy` falls at once and that neither `erase_hold` nor mode 3 appears after the suspend delay has elapsed. A second overlap is a program launched during a suspension whose completion must clear only the program. This is judged by `busy` returning low while `erase_hold` stays set until a plane-matching resume.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {MD_READ = 2'd0, MD_ID = 2'd1, MD_BYP = 2'd2, MD_SUSP = 2'd3} mode_e;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SERASE = 2'd1, OP_CERASE = 2'd2, OP_LOCK = 2'd3} op_e;
  typedef enum logic [3:0] {
    EV_NONE, EV_MISM, EV_PROG, EV_SERASE, EV_CERASE, EV_LOCK,
    EV_BYP, EV_ID, EV_EXIT, EV_SUSP, EV_RESUME
  } ev_e;

  localparam logic [7:0] C_PROG      = 8'hA0;
  localparam logic [7:0] C_ERASE_PRE = 8'h80;
  localparam logic [7:0] C_LOCK_PRE  = 8'h60;
  localparam logic [7:0] C_ID        = 8'h90;
  localparam logic [7:0] C_EXIT      = 8'hF0;
  localparam logic [7:0] C_SERASE    = 8'h30;
  localparam logic [7:0] C_CERASE    = 8'h10;
  localparam logic [7:0] C_BYP       = 8'h20;
  localparam logic [7:0] C_LOCK      = 8'h40;
  localparam logic [7:0] C_SUSP      = 8'hB0;
  localparam logic [7:0] C_RESUME    = 8'h30;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int UNLK_W = 11,
  parameter logic [UNLK_W-1:0] U1_ADDR = 11'h555,
  parameter logic [UNLK_W-1:0] U2_ADDR = 11'h2AA,
  parameter logic [7:0] U1_DATA = 8'hAA,
  parameter logic [7:0] U2_DATA = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [UNLK_W-1:0] addr_lo,
  input  logic [7:0]        code,
  output ev_e               ev
);
  logic [2:0] idx_q, idx_d;
  logic [7:0] cmd_q, cmd_d;
  logic hit1, hit2, mism;

  assign hit1 = (addr_lo == U1_ADDR);
  assign hit2 = (addr_lo == U2_ADDR);

  always_comb begin
    ev    = EV_NONE;
    idx_d = idx_q;
    cmd_d = cmd_q;
    mism  = 1'b0;
    if (step) begin
      case (idx_q)
        3'd0: begin
          if (hit1 && code == U1_DATA) idx_d = 3'd1;
          else if (code == C_EXIT)     ev = EV_EXIT;
          else if (code == C_SUSP)     ev = EV_SUSP;
          else if (code == C_RESUME)   ev = EV_RESUME;
          else                         mism = 1'b1;
        end
        3'd1: begin
          if (hit2 && code == U2_DATA) idx_d = 3'd2;
          else                         mism = 1'b1;
        end
        3'd2: begin
          if (hit1 && (code == C_PROG || code == C_ERASE_PRE || code == C_LOCK_PRE)) begin
            idx_d = 3'd3;
            cmd_d = code;
          end else if (hit1 && code == C_ID) begin
            ev    = EV_ID;
            idx_d = 3'd0;
          end else mism = 1'b1;
        end
        3'd3: begin
          if (cmd_q == C_PROG) begin
            ev    = EV_PROG;
            idx_d = 3'd0;
          end else if (hit1 && code == U1_DATA) idx_d = 3'd4;
          else mism = 1'b1;
        end
        3'd4: begin
          if (hit2 && code == U2_DATA) idx_d = 3'd5;
          else                         mism = 1'b1;
        end
        default: begin
          idx_d = 3'd0;
          if (cmd_q == C_ERASE_PRE) begin
            if (code == C_SERASE)            ev = EV_SERASE;
            else if (hit1 && code == C_CERASE) ev = EV_CERASE;
            else if (hit1 && code == C_BYP)    ev = EV_BYP;
            else                               mism = 1'b1;
          end else begin
            if (code == C_LOCK) ev = EV_LOCK;
            else                mism = 1'b1;
          end
        end
      endcase
      if (mism) begin
        ev    = EV_MISM;
        idx_d = 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 3'd0;
      cmd_q <= 8'h00;
    end else begin
      idx_q <= idx_d;
      cmd_q <= cmd_d;
    end
  end

  // R12: a broken sequence always restarts from the first unlock cycle
  assert_mism_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_MISM) |=> (idx_q == 3'd0));
endmodule

// File: rtl/fcd_opstate.sv
module fcd_opstate #(
  parameter int SECT_W   = 4,
  parameter int SUSP_DLY = 8,
  localparam int CNT_W   = $clog2(SUSP_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_short,
  input  logic              start_erase,
  input  logic              erase_plane_i,
  input  logic [SECT_W-1:0] erase_sect_i,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              op_done,
  output logic              short_run,
  output logic              erase_run,
  output logic              susp_pend,
  output logic              susp_on,
  output logic              erase_plane,
  output logic [SECT_W-1:0] erase_sect
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_run   <= 1'b0;
      erase_run   <= 1'b0;
      susp_pend   <= 1'b0;
      susp_on     <= 1'b0;
      erase_plane <= 1'b0;
      erase_sect  <= '0;
      cnt_q       <= '0;
    end else begin
      if (op_done) begin
        if (short_run) short_run <= 1'b0;
        else if (erase_run && !susp_on) erase_run <= 1'b0;
      end
      if (start_short) short_run <= 1'b1;
      if (start_erase) begin
        erase_run   <= 1'b1;
        erase_plane <= erase_plane_i;
        erase_sect  <= erase_sect_i;
      end
      if (susp_req) begin
        susp_pend <= 1'b1;
        cnt_q     <= CNT_W'(SUSP_DLY);
      end else if (op_done && !short_run) begin
        susp_pend <= 1'b0;
      end else if (susp_pend) begin
        if (cnt_q == CNT_W'(1)) begin
          susp_pend <= 1'b0;
          susp_on   <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
      end
      if (resume_req) susp_on <= 1'b0;
    end
  end

  // R8: suspension is granted only at the end of a pending window
  assert_susp_after_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_on) |-> $past(susp_pend));
  // R9: resume is only requested for a suspended erase
  assert_resume_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> susp_on);
  // R7: a short operation is never launched on top of another
  assert_short_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_short |-> !short_run);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int UNLK_W     = 11,
  parameter int PLANE_BITS = 3,
  parameter int SECT_LSB   = 15,
  parameter int SUSP_DLY   = 8,
  localparam int SECT_W    = ADDR_W - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              start_valid,
  output logic [1:0]        start_op,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_data,
  output logic              start_plane,
  output logic [1:0]        mode,
  output logic              busy,
  output logic              erase_hold
);
  mode_e mode_q, mode_d;
  ev_e   ev;
  logic short_run, erase_run, susp_pend, susp_on, erase_plane;
  logic [SECT_W-1:0] erase_sect, wr_sect;
  logic [7:0] code;
  logic blocked, byp, seq_step, susp_req, resume_req, wr_plane;
  logic do_prog, do_erase, do_lock, chip;

  assign code     = wr_data[7:0];
  assign wr_plane = (wr_addr[ADDR_W-1 -: PLANE_BITS] != '0);
  assign wr_sect  = wr_addr[ADDR_W-1:SECT_LSB];
  assign blocked  = short_run | susp_pend | (erase_run & ~susp_on);
  assign byp      = (mode_q == MD_BYP);
  assign seq_step = wr_valid & ~blocked & ~byp;
  assign susp_req = wr_valid & erase_run & ~susp_on & ~susp_pend & ~short_run
                    & ~op_done & (code == C_SUSP);

  fcd_seq #(.UNLK_W(UNLK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(seq_step),
    .addr_lo(wr_addr[UNLK_W-1:0]), .code(code), .ev(ev)
  );

  assign chip       = (ev == EV_CERASE);
  assign do_prog    = (byp & wr_valid & ~blocked)
                    | ((ev == EV_PROG) & ~(susp_on & (wr_sect == erase_sect)));
  assign do_erase   = ((ev == EV_SERASE) | chip) & ~susp_on;
  assign do_lock    = (ev == EV_LOCK);
  assign resume_req = (ev == EV_RESUME) & susp_on & (wr_plane == erase_plane);

  fcd_opstate #(.SECT_W(SECT_W), .SUSP_DLY(SUSP_DLY)) u_ops (
    .clk(clk), .rst_n(rst_n),
    .start_short(do_prog | do_lock), .start_erase(do_erase),
    .erase_plane_i(chip ? 1'b0 : wr_plane), .erase_sect_i(wr_sect),
    .susp_req(susp_req), .resume_req(resume_req), .op_done(op_done),
    .short_run(short_run), .erase_run(erase_run), .susp_pend(susp_pend),
    .susp_on(susp_on), .erase_plane(erase_plane), .erase_sect(erase_sect)
  );

  always_comb begin
    case (ev)
      EV_NONE, EV_SUSP: mode_d = mode_q;
      EV_ID:            mode_d = MD_ID;
      EV_BYP:           mode_d = susp_on ? MD_READ : MD_BYP;
      default:          mode_d = MD_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MD_READ;
      start_valid <= 1'b0;
      start_op    <= OP_PROG;
      start_addr  <= '0;
      start_data  <= '0;
      start_plane <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      start_valid <= do_prog | do_erase | do_lock;
      if (do_prog | do_erase | do_lock) begin
        start_op    <= do_prog ? OP_PROG : do_lock ? OP_LOCK : chip ? OP_CERASE : OP_SERASE;
        start_addr  <= wr_addr;
        start_data  <= wr_data;
        start_plane <= chip ? 1'b0 : wr_plane;
      end
    end
  end

  assign mode       = (mode_q == MD_READ && susp_on) ? MD_SUSP : mode_q;
  assign busy       = short_run | (erase_run & ~susp_on) | susp_pend;
  assign erase_hold = susp_on;

  // R6: bypass is left only through reset
  assert_bypass_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BYP) |=> (mode_q == MD_BYP));
  // R7: nothing is launched from a write taken while a short op ran
  assert_no_start_in_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> !$past(short_run));
  // R10: no erase launch while an erase is held
  assert_no_erase_in_susp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && (start_op == OP_SERASE || start_op == OP_CERASE)) |-> !$past(susp_on));
  // R2: a launch is immediately reflected as busy
  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> busy);
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int SUSP_DLY   = 8;
  localparam int N          = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic op_done = 1'b0;
  logic start_valid, start_plane, busy, erase_hold;
  logic [1:0] start_op, mode;
  logic [18:0] start_addr;
  logic [15:0] start_data;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.SUSP_DLY(SUSP_DLY)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .start_valid(start_valid),
    .start_op(start_op), .start_addr(start_addr), .start_data(start_data),
    .start_plane(start_plane), .mode(mode), .busy(busy), .erase_hold(erase_hold)
  );

  // {addr, data, expect launch, expect op, expect mode, pulse done}
  localparam logic [40:0] TBL [N] = '{
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},  // R2 program
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h00A0, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h01234, 16'hBEEF, 1'b1, 2'd0, 2'd0, 1'b1},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},  // R13 id entry
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h0090, 1'b0, 2'd0, 2'd1, 1'b0},
    {19'h00000, 16'h00F0, 1'b0, 2'd0, 2'd0, 1'b0},  // R13 exit
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},  // R12 mismatch from id
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h0090, 1'b0, 2'd0, 2'd1, 1'b0},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd1, 1'b0},
    {19'h00123, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'hFFAA, 1'b0, 2'd0, 2'd0, 1'b0},  // R11 upper byte ignored
    {19'h002AA, 16'h1255, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h77A0, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00100, 16'h0000, 1'b1, 2'd0, 2'd0, 1'b1},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},  // R4 lock
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h0060, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h08000, 16'h0040, 1'b1, 2'd3, 2'd0, 1'b1},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},  // R4 chip erase
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h0080, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h0010, 1'b1, 2'd2, 2'd0, 1'b1},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},  // R3 sector erase
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h0080, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h00555, 16'h00AA, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h002AA, 16'h0055, 1'b0, 2'd0, 2'd0, 1'b0},
    {19'h20000, 16'h0030, 1'b1, 2'd1, 2'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic unlock3(input logic [7:0] c);
    wr(19'h00555, 16'h00AA); wr(19'h002AA, 16'h0055); wr(19'h00555, {8'h00, c});
  endtask

  task automatic erase6(input logic [18:0] a, input logic [7:0] c);
    unlock3(8'h80); wr(19'h00555, 16'h00AA); wr(19'h002AA, 16'h0055);
    wr(a, {8'h00, c});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", mode, 2'd0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 hold", erase_hold, 1'b0);
    chk("R1 start", start_valid, 1'b0);

    for (int i = 0; i < N; i++) begin
      wr(TBL[i][40:22], TBL[i][21:6]);
      chk($sformatf("R2/R3/R4 vec%0d start", i), start_valid, TBL[i][5]);
      if (TBL[i][5]) begin
        chk($sformatf("R2/R3/R4 vec%0d op", i), start_op, TBL[i][4:3]);
        chk($sformatf("R2/R11 vec%0d addr", i), start_addr, TBL[i][40:22]);
        chk($sformatf("R2/R11 vec%0d data", i), start_data, TBL[i][21:6]);
      end
      chk($sformatf("R12/R13 vec%0d mode", i), mode, TBL[i][2:1]);
      if (TBL[i][0]) begin
        done_pulse();
        chk($sformatf("vec%0d busy after done", i), busy, 1'b0);
      end
    end

    // R7: writes during a running program are dropped
    unlock3(8'hA0); wr(19'h00040, 16'h1111);
    chk("R7 first launch", start_valid, 1'b1);
    unlock3(8'hA0);
    chk("R7 busy held", busy, 1'b1);
    wr(19'h00050, 16'h2222);
    chk("R7 no launch", start_valid, 1'b0);
    done_pulse();
    wr(19'h00060, 16'h3333);
    chk("R7 sequence not advanced", start_valid, 1'b0);

    // R8: completion and suspend code in the same cycle
    erase6(19'h50000, 8'h30);
    chk("R3 plane", start_plane, 1'b1);
    op_done = 1'b1;
    wr(19'h00000, 16'h00B0);
    op_done = 1'b0;
    chk("R8 completion wins busy", busy, 1'b0);
    repeat (SUSP_DLY + 1) @(negedge clk);
    chk("R8 no suspend after completion", erase_hold, 1'b0);
    chk("R8 mode read", mode, 2'd0);

    // R8: suspend delay
    erase6(19'h50000, 8'h30);
    wr(19'h00000, 16'h00B0);
    repeat (SUSP_DLY - 1) @(negedge clk);
    chk("R8 busy during delay", busy, 1'b1);
    chk("R8 not yet held", erase_hold, 1'b0);
    @(negedge clk);
    chk("R8 held", erase_hold, 1'b1);
    chk("R8 busy released", busy, 1'b0);
    chk("R8 mode suspended", mode, 2'd3);

    // R10: refusals and accepted program while suspended
    erase6(19'h20000, 8'h30);
    chk("R10 erase refused", start_valid, 1'b0);
    unlock3(8'hA0); wr(19'h50010, 16'h0AAA);
    chk("R10 same sector refused", start_valid, 1'b0);
    unlock3(8'hA0); wr(19'h10000, 16'h00F0);
    chk("R10 other sector launched", start_valid, 1'b1);
    chk("R10 other sector addr", start_addr, 19'h10000);
    done_pulse();
    chk("R10 busy after program", busy, 1'b0);
    chk("R10 still held", erase_hold, 1'b1);

    // R9: plane-scoped resume
    wr(19'h00000, 16'h0030);
    chk("R9 wrong plane ignored", erase_hold, 1'b1);
    wr(19'h40000, 16'h0030);
    chk("R9 resumed", erase_hold, 1'b0);
    chk("R9 busy again", busy, 1'b1);
    chk("R9 mode read", mode, 2'd0);
    done_pulse();
    chk("R9 erase complete", busy, 1'b0);

    // R5/R6: bypass
    erase6(19'h00555, 8'h20);
    chk("R5 bypass mode", mode, 2'd2);
    chk("R5 no launch on entry", start_valid, 1'b0);
    wr(19'h00300, 16'h00B0);
    chk("R6 suspend code programmed", start_valid, 1'b1);
    chk("R6 data", start_data, 16'h00B0);
    done_pulse();
    wr(19'h00555, 16'h00AA);
    chk("R5 single write program", start_valid, 1'b1);
    chk("R5 addr", start_addr, 19'h00555);
    done_pulse();
    wr(19'h00000, 16'h00F0);
    chk("R6 exit code programmed", start_valid, 1'b1);
    chk("R6 still bypass", mode, 2'd2);
    done_pulse();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset leaves bypass", mode, 2'd0);
    chk("R1 busy after reset", busy, 1'b0);

    summary();
  end
endmodule